// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write an external asynchronous static RAM of 256K 16-bit words with a separate enable for each byte lane. The host issues one access at a time over a request/ready handshake: word address, a read/write flag, write data and a two-bit byte mask. Completed reads come back with a one-cycle valid pulse.

On the memory side the controller drives the address bus and the active-low chip enable, write strobe, output enable and two lane enables. It also drives a split data bus (output value, output enable, input value) meant for a tri-state pad. Access lengths are given in clock cycles and raised to the memory's nanosecond minimums for the clock period parameter. Output enable stays high for the whole write so the shortest write pulse applies. A write that follows a read directly waits extra turnaround cycles, so the memory's drivers release the bus before the controller drives it.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, ready is 1 and rdValid is 0. memCeN, memWeN and memOeN are 1, memBeN is 2'b11 and memDataOe is 0.
- R2: A read accepted when req and ready are both 1 (with wr = 0) holds ready at 0 for RD cycles, where RD = max(READ_WAIT_CYC, ceil(10 / CLK_NS)). In each of those cycles memCeN = 0, memOeN = 0 and memWeN = 1.
- R3: rdValid is a single-cycle pulse in the cycle after the last read cycle, and ready is 1 in that cycle. rdData carries memDataIn as it was in the last read cycle, with every lane whose mask bit is 0 forced to zero.
- R4: An accepted write (wr = 1) runs in three phases. First comes one setup cycle: chip and lane enables low, memWeN = 1, no drive. Then WP cycles with memWeN = 0, where WP = max(WR_PULSE_CYC, ceil(8 / CLK_NS), ceil(5 / CLK_NS)). Last comes one hold cycle with memWeN = 1, memCeN = 0 and memDataOe = 0. Ready returns to 1 in the next cycle.
- R5: memOeN is 1 in every cycle of a write. memDataOe is 1 exactly in the cycles where memWeN is 0, and memDataOut then equals the accepted write data.
- R6: byteMask bit 0 selects data bits 7..0 and drives memBeN[0]; bit 1 selects bits 15..8 and drives memBeN[1]. During an access memBeN = ~byteMask, so lanes whose mask bit is 0 are not written. A write with mask 2'b00 leaves the memory unchanged.
- R7: A write accepted in the cycle right after a read completes first spends TURN_CYC cycles with all memory controls inactive and ready at 0. A write accepted at any other time starts its setup cycle at once.
- R8: Whenever ready is 1, memCeN, memWeN and memOeN are 1, memBeN is 2'b11 and memDataOe is 0.
- R9: memAddr equals the accepted address and does not change for every cycle in which memCeN is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host access request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wrData | input | 16 | Write data |
| byteMask | input | 2 | Lane select, bit 0 = low byte |
| ready | output | 1 | Controller idle, request accepted |
| rdData | output | 16 | Read data |
| rdValid | output | 1 | Read data valid pulse |
| memAddr | output | 18 | Memory address bus |
| memDataOut | output | 16 | Data to the pad output |
| memDataOe | output | 1 | Pad output enable |
| memDataIn | input | 16 | Data from the pad input |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memBeN | output | 2 | Lane enables, active low |

## Verification
The bound checker checks these on every cycle:
- pins idle whenever ready is high;
- output enable never low while the write strobe is low;
- data driven only under a low write strobe;
- lane enables only under chip enable;
- the address stable across an enabled access;
- rdValid never high two cycles in a row.

The cycle counts themselves can only be shown by the bench scenarios: RD and WP for this clock period, and the turnaround inserted only directly after a read. The same holds for correct lane masking of write and read data and for the behaviour with an empty mask. The bench checks these against a behavioural memory model and a reference copy of the contents.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_TURN  = 3'd2,
    ST_SETUP = 3'd3,
    ST_PULSE = 3'd4,
    ST_HOLD  = 3'd5
  } portState_e;

  typedef struct packed {
    logic accept;
    logic capture;
    logic ceActive;
    logic oeActive;
    logic weActive;
    logic drive;
  } strobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_port_fsm.sv
module sram_port_fsm
  import sram_port_pkg::*;
#(
  parameter int RD_CYC   = 3,
  parameter int WP_CYC   = 2,
  parameter int TURN_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    wr,
  output logic    ready,
  output strobe_t ctl
);

  localparam int MAX_CNT = maxOf(maxOf(RD_CYC, WP_CYC), maxOf(TURN_CYC, 1));
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  portState_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic afterRead;

  always_comb begin
    stateNext   = state;
    cntNext     = cnt;
    ctl.accept  = 1'b0;
    ctl.capture = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req) begin
          ctl.accept = 1'b1;
          if (!wr) begin
            stateNext = ST_READ;
            cntNext   = CNT_W'(RD_CYC - 1);
          end else if (afterRead && (TURN_CYC > 0)) begin
            stateNext = ST_TURN;
            cntNext   = CNT_W'(maxOf(TURN_CYC, 1) - 1);
          end else begin
            stateNext = ST_SETUP;
          end
        end
      end
      ST_READ: begin
        if (cnt == '0) begin
          ctl.capture = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt == '0) stateNext = ST_SETUP;
        else           cntNext   = cnt - 1'b1;
      end
      ST_SETUP: begin
        stateNext = ST_PULSE;
        cntNext   = CNT_W'(WP_CYC - 1);
      end
      ST_PULSE: begin
        if (cnt == '0) stateNext = ST_HOLD;
        else           cntNext   = cnt - 1'b1;
      end
      ST_HOLD:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      afterRead <= 1'b0;
    end else begin
      state     <= stateNext;
      cnt       <= cntNext;
      afterRead <= ctl.capture;
    end
  end

  assign ready        = (state == ST_IDLE);
  assign ctl.ceActive = (state == ST_READ) || (state == ST_SETUP) ||
                        (state == ST_PULSE) || (state == ST_HOLD);
  assign ctl.oeActive = (state == ST_READ);
  assign ctl.weActive = (state == ST_PULSE);
  assign ctl.drive    = (state == ST_PULSE);

endmodule

// File: rtl/sram_port_dp.sv
module sram_port_dp
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [LANES-1:0]  hostMask,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memBeN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] laneBits;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneBits[g*LANE_W +: LANE_W] = {LANE_W{maskQ[g]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      maskQ   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (ctl.accept) begin
        addrQ <= hostAddr;
        dataQ <= hostWrData;
        maskQ <= hostMask;
      end
      if (ctl.capture) rdData <= memDataIn & laneBits;
      rdValid <= ctl.capture;
    end
  end

  assign memAddr    = addrQ;
  assign memDataOut = dataQ;
  assign memDataOe  = ctl.drive;
  assign memCeN     = ~ctl.ceActive;
  assign memOeN     = ~ctl.oeActive;
  assign memWeN     = ~ctl.weActive;
  assign memBeN     = ctl.ceActive ? ~maskQ : '1;

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_NS        = 4,
  parameter int READ_WAIT_CYC = 1,
  parameter int WR_PULSE_CYC  = 1,
  parameter int TURN_CYC      = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                req,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W/8-1:0] byteMask,
  output logic                ready,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memDataOut,
  output logic                memDataOe,
  input  logic [DATA_W-1:0]   memDataIn,
  output logic                memCeN,
  output logic                memWeN,
  output logic                memOeN,
  output logic [DATA_W/8-1:0] memBeN
);

  localparam int LANES  = DATA_W / 8;
  localparam int RD_CYC = maxOf(READ_WAIT_CYC, ceilDiv(10, CLK_NS));
  localparam int WP_CYC = maxOf(WR_PULSE_CYC,
                                maxOf(ceilDiv(8, CLK_NS), ceilDiv(5, CLK_NS)));

  strobe_t ctl;

  sram_port_fsm #(
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk  (clk),
    .rstN (rstN),
    .req  (req),
    .wr   (wr),
    .ready(ready),
    .ctl  (ctl)
  );

  sram_port_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .hostAddr  (addr),
    .hostWrData(wrData),
    .hostMask  (byteMask),
    .memDataIn (memDataIn),
    .memAddr   (memAddr),
    .memDataOut(memDataOut),
    .memDataOe (memDataOe),
    .memCeN    (memCeN),
    .memWeN    (memWeN),
    .memOeN    (memOeN),
    .memBeN    (memBeN),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

endmodule

// File: rtl/sram_port_checker.sv
module sram_port_checker #(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memDataOe,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic [LANES-1:0]  memBeN
);

  assert_idle_pins_R8: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (memCeN && memWeN && memOeN && !memDataOe && (memBeN == '1)));

  assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  assert_drive_with_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe == !memWeN);

  assert_hold_after_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCeN && !memDataOe));

  assert_lanes_under_ce_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memBeN != '1) |-> !memCeN);

  assert_rdvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  assert_no_pulse_after_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(!memOeN) |-> (memWeN && !memDataOe));

endmodule

bind sram_port_ctrl sram_port_checker #(.ADDR_W(ADDR_W), .LANES(DATA_W/8)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ready    (ready),
  .rdValid  (rdValid),
  .memAddr  (memAddr),
  .memDataOe(memDataOe),
  .memCeN   (memCeN),
  .memWeN   (memWeN),
  .memOeN   (memOeN),
  .memBeN   (memBeN)
);

// File: tb/sram_port_ctrl_bench.sv
`timescale 1ns/1ps
module sram_port_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DUT_NS     = 4;
  localparam int TURN_EXP   = 1;
  // Expected lengths computed from the nanosecond rules in R2 / R4
  localparam int RD_EXP = ((10 + DUT_NS - 1) / DUT_NS > 1) ? (10 + DUT_NS - 1) / DUT_NS : 1;
  localparam int WP_EXP = ((8 + DUT_NS - 1) / DUT_NS > 1) ? (8 + DUT_NS - 1) / DUT_NS : 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  byteMask = '0;
  logic        ready, rdValid, memDataOe, memCeN, memWeN, memOeN;
  logic [15:0] rdData, memDataOut, memDataIn;
  logic [17:0] memAddr;
  logic [1:0]  memBeN;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] sram   [0:255];
  logic [15:0] refMem [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_port_ctrl #(.CLK_NS(DUT_NS), .TURN_CYC(TURN_EXP)) u_sram_port_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .wr(wr), .addr(addr), .wrData(wrData),
    .byteMask(byteMask), .ready(ready), .rdData(rdData), .rdValid(rdValid),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .memDataIn(memDataIn), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memBeN(memBeN)
  );

  // Behavioural asynchronous memory: disabled lanes return 8'hEE
  always_comb begin
    if (!memCeN && !memOeN && memWeN)
      memDataIn = {memBeN[1] ? 8'hEE : sram[memAddr[7:0]][15:8],
                   memBeN[0] ? 8'hEE : sram[memAddr[7:0]][7:0]};
    else
      memDataIn = 16'hFFFF;
  end

  always @(negedge clk) begin
    if (!memCeN && !memWeN) begin
      if (!memBeN[0]) sram[memAddr[7:0]][7:0]  <= memDataOut[7:0];
      if (!memBeN[1]) sram[memAddr[7:0]][15:8] <= memDataOut[15:8];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-clock invariants
  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (ready)
        chk(memCeN && memWeN && memOeN && !memDataOe && memBeN == 2'b11,
            "R8 idle pins", {memCeN, memWeN, memOeN, memDataOe, memBeN}, 6'b111011);
      if (memDataOe)
        chk(!memWeN && memOeN, "R5 drive only in pulse", {memWeN, memOeN}, 2'b01);
      chk(!(prevValid && rdValid), "R3 single pulse", rdValid, 0);
      prevValid = rdValid;
    end
  end

  function automatic logic [15:0] laneMask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic doRead(input logic [17:0] a, input logic [1:0] m);
    logic [15:0] exp;
    exp = refMem[a[7:0]] & laneMask(m);
    req = 1; wr = 0; addr = a; byteMask = m;
    @(negedge clk); req = 0;
    for (int i = 0; i < RD_EXP; i++) begin
      chk(!ready && !memCeN && !memOeN && memWeN, "R2 read pins",
          {ready, memCeN, memOeN, memWeN}, 4'b0001);
      chk(memBeN == ~m, "R6 read lanes", memBeN, ~m);
      chk(memAddr == a, "R9 read addr", memAddr, a);
      @(negedge clk);
    end
    chk(rdValid && ready, "R3 valid timing", {rdValid, ready}, 2'b11);
    chk(rdData == exp, "R3 read data", rdData, exp);
  endtask

  task automatic doWrite(input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] m, input bit expTurn);
    req = 1; wr = 1; addr = a; wrData = d; byteMask = m;
    @(negedge clk); req = 0;
    if (expTurn) begin
      for (int i = 0; i < TURN_EXP; i++) begin
        chk(!ready && memCeN && memWeN && memOeN && !memDataOe, "R7 turnaround",
            {ready, memCeN, memWeN, memOeN, memDataOe}, 5'b01110);
        @(negedge clk);
      end
    end
    chk(!ready && !memCeN && memWeN && memOeN && !memDataOe, "R4 setup",
        {ready, memCeN, memWeN, memOeN, memDataOe}, 5'b00110);
    chk(memBeN == ~m && memAddr == a, "R6 write lanes", {memBeN, memAddr}, {~m, a});
    @(negedge clk);
    for (int i = 0; i < WP_EXP; i++) begin
      chk(!memWeN && memDataOe && memOeN && !memCeN, "R5 pulse",
          {memWeN, memDataOe, memOeN, memCeN}, 4'b0110);
      chk(memDataOut == d, "R5 write data", memDataOut, d);
      @(negedge clk);
    end
    chk(!ready && memWeN && !memCeN && !memDataOe && memAddr == a, "R4 hold",
        {ready, memWeN, memCeN, memDataOe}, 4'b0100);
    @(negedge clk);
    chk(ready, "R4 ready after write", ready, 1);
    if (m[0]) refMem[a[7:0]][7:0]  = d[7:0];
    if (m[1]) refMem[a[7:0]][15:8] = d[15:8];
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      sram[i]   = 16'(i * 257) ^ 16'h5A5A;
      refMem[i] = 16'(i * 257) ^ 16'h5A5A;
    end
    repeat (3) @(negedge clk);
    chk(ready && !rdValid && memCeN && memWeN && memOeN && memBeN == 2'b11 && !memDataOe,
        "R1 reset state", {ready, rdValid, memCeN, memWeN, memOeN, memBeN, memDataOe},
        8'b10111110);
    rstN = 1;
    @(negedge clk);

    doWrite(18'h00010, 16'hA5C3, 2'b11, 0);   // R4 full word
    @(negedge clk);
    doRead(18'h00010, 2'b11);                 // R2 R3
    @(negedge clk);
    doWrite(18'h00010, 16'h1234, 2'b01, 0);   // R6 low lane only
    doWrite(18'h00010, 16'h5678, 2'b10, 0);   // R6 high lane only
    doRead(18'h00010, 2'b11);
    @(negedge clk);
    doRead(18'h00010, 2'b01);                 // R3 upper lane zeroed
    @(negedge clk);
    doRead(18'h00010, 2'b10);                 // R3 lower lane zeroed
    @(negedge clk);
    doWrite(18'h3FFFF, 16'hBEEF, 2'b11, 0);   // top address
    doRead(18'h3FFFF, 2'b11);
    doWrite(18'h00021, 16'hCAFE, 2'b11, 1);   // R7 write right after read
    doRead(18'h00021, 2'b11);
    doRead(18'h00010, 2'b11);                 // read right after read: no turn
    @(negedge clk);
    doWrite(18'h00021, 16'h0F0F, 2'b11, 0);   // R7 write later: no turn
    doWrite(18'h00021, 16'hFFFF, 2'b00, 0);   // R6 empty mask
    doRead(18'h00021, 2'b11);
    @(negedge clk);
    chk(sram[8'h21] == 16'h0F0F, "R6 empty mask no change", sram[8'h21], 16'h0F0F);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule